// File: doc/BRIEF.md
# I2C Target with Interrupt-Driven Clock Stretching

This block is the target (slave) half of an I2C-style serial interface. The slave engine runs whenever the master-select bit in the control register is 0. It watches the synchronised SCL and SDA lines for a START condition. It then shifts in a seven-bit address and the direction bit, and compares the address with a programmable own-address register. The all-zero write address is accepted as a general call. For an accepted address the block acknowledges on the ninth clock. It then raises an interrupt and holds SCL low until software services the transfer.

Each transfer is serviced through a small register interface with a data buffer, a control register, a status register and the own-address register. An interrupt clears a pending-not flag and stretches the clock. Software releases the clock by touching the data buffer or by writing the pending-not bit back to 1. The line is let go after a fixed hold interval. When the unit has been bidding as a master and loses arbitration, it goes on counting the bus word to its end. It then interrupts with the arbitration-lost flag set and drops into slave mode.

Both bus lines are open-drain style: `sclOe`/`sdaOe` high means the pin is pulled low.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset `sclOe`, `sdaOe` and `irq` are 0. The status register reads 0x10, the control register reads 0x00 and the own-address register reads the reset parameter (0x3C by default).
- R2: Register map: address 0 is the data buffer, 1 is control (bit 0 = master select), 2 is status and 3 is the own address. Status bits: bit 4 = pending-not, bit 3 = arbitration lost, bit 2 = transmit direction, bit 1 = addressed as slave, bit 0 = general call. For an address equal to the own address, the block pulls SDA low during the ninth clock and sets addressed-as-slave. Transmit direction takes the R/W bit. Then it raises the interrupt and holds SCL low.
- R3: An address byte that is neither the own address nor the general call is not acknowledged and raises no interrupt. The data bytes that follow until the next START are ignored, and the data buffer keeps its value.
- R4: Address 0x00 with R/W = 0 is a general call: it is acknowledged and sets general-call and addressed-as-slave. Each following data byte is acknowledged, captured and interrupts. Address 0x00 with R/W = 1 is not accepted.
- R5: An interrupt clears pending-not (`irq` = NOT pending-not) and drives SCL low. A read or write of the data buffer, or a status write with bit 4 = 1, while pending starts the hold. SCL is released and pending-not set exactly HOLD_CYC clock edges after the access edge.
- R6: In receive direction each data byte is acknowledged, stored in the data buffer (MSB first on the bus) and followed by an interrupt.
- R7: In transmit direction a data-buffer write during the stretch loads the byte, which is shifted out MSB first. A master ACK on the ninth clock raises the interrupt and stretches; a NACK raises none and leaves both lines released.
- R8: With master select = 1, the block never acknowledges. A pulse on `arbLost` lets the current word finish. At the end of its ninth clock the block interrupts, sets arbitration lost and clears master select.
- R9: Any write to the control register clears arbitration lost.
- R10: A STOP condition clears addressed-as-slave.
- R11: The block only starts pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| sclOe | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaOe | output | 1 | 1 pulls SDA low (ACK or data 0) |
| arbLost | input | 1 | One-cycle pulse from the master engine: arbitration lost |
| regAddr | input | 2 | Register select |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt, high while a transfer is pending |

## Verification
The assertions check several rules on every cycle. SCL stays pulled low for as long as the pending flag is clear. The flag returns at the moment SCL is let go. SDA is only ever newly pulled low while the synchronised clock is low. A STOP always clears the addressed flag, and the arbitration-lost flag never rises while master select is still set. Other behaviour needs a bus master driving real frames, and only the bench scenarios can show it. This covers address acceptance and rejection, general-call data capture, MSB-first transmit with ACK versus NACK endings, the exact release latency of the hold, and the word-end handover after lost arbitration.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);
  localparam int STAT_W = 5;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_OWN  = 2'd3;

  // status bit positions
  localparam int STAT_PIN = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_TX
  } phase_t;

  // bus events reported by the datapath
  typedef struct packed {
    logic             sclRise;
    logic             sclFall;
    logic             startDet;
    logic             stopDet;
    logic             sdaBit;
    logic             addrMatch;
    logic             genCall;
    logic             rwBit;
    logic [CNT_W-1:0] bitCnt;
  } busEv_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic capture;
    logic ackLow;
    logic sdaFree;
  } dpStrobe_t;

endpackage

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int                SYNC_LEN     = 2,
  parameter logic [ADDR_W-1:0] OWN_ADDR_RST = 7'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         stb,
  input  logic              hostDataWr,
  input  logic              hostOwnWr,
  input  logic [BYTE_W-1:0] hostWdata,
  output busEv_t            ev,
  output logic [BYTE_W-1:0] dataBuf,
  output logic [ADDR_W-1:0] ownAddr,
  output logic              sdaOe
);

  logic [SYNC_LEN-1:0] sclSync;
  logic [SYNC_LEN-1:0] sdaSync;
  logic                sclPrev;
  logic                sdaPrev;
  logic                sclS;
  logic                sdaS;
  logic [BYTE_W-1:0]   shifter;
  logic [CNT_W-1:0]    bitCnt;

  // input synchronisers, idle bus level is high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_LEN-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_LEN-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclSync[SYNC_LEN-1];
  assign sdaS = sdaSync[SYNC_LEN-1];

  assign ev.sclRise   = sclS & ~sclPrev;
  assign ev.sclFall   = ~sclS & sclPrev;
  assign ev.startDet  = sclS & sclPrev & sdaPrev & ~sdaS;
  assign ev.stopDet   = sclS & sclPrev & ~sdaPrev & sdaS;
  assign ev.sdaBit    = sdaS;
  assign ev.addrMatch = (shifter[BYTE_W-1:1] == ownAddr);
  assign ev.genCall   = (shifter == '0);
  assign ev.rwBit     = shifter[0];
  assign ev.bitCnt    = bitCnt;

  // shift register shared by receive and transmit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shifter <= '0;
    end else if (stb.loadTx) begin
      shifter <= hostWdata;
    end else if (stb.shiftIn) begin
      shifter <= {shifter[BYTE_W-2:0], sdaS};
    end else if (stb.shiftOut) begin
      shifter <= {shifter[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (stb.cntClr) begin
      bitCnt <= '0;
    end else if (stb.cntInc) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataBuf <= '0;
      ownAddr <= OWN_ADDR_RST;
    end else begin
      if (hostDataWr) begin
        dataBuf <= hostWdata;
      end else if (stb.capture) begin
        dataBuf <= shifter;
      end
      if (hostOwnWr) begin
        ownAddr <= hostWdata[ADDR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaOe <= 1'b0;
    end else if (stb.sdaFree) begin
      sdaOe <= 1'b0;
    end else if (stb.ackLow) begin
      sdaOe <= 1'b1;
    end else if (stb.loadTx) begin
      sdaOe <= ~hostWdata[BYTE_W-1];
    end else if (stb.shiftOut) begin
      sdaOe <= ~shifter[BYTE_W-2];
    end
  end

  AST_SDA_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS); // R11

  AST_SYNC_DEPTH: assert final (SYNC_LEN >= 2); // R11

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic              arbLost,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              wdMst,
  input  logic              wdPin,
  output dpStrobe_t         stb,
  output logic              sclOe,
  output logic              mstSel,
  output logic [STAT_W-1:0] status
);

  localparam int HC_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] DATA_END = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] WORD_END = CNT_W'(BYTE_W + 1);

  phase_t          state, stateNxt;
  logic            aas, aasNxt;
  logic            trx, trxNxt;
  logic            ad0, ad0Nxt;
  logic            al, alNxt;
  logic            alPend, alPendNxt;
  logic            mstNxt;
  logic            ackBit, ackBitNxt;
  logic            pinN;
  logic            raise;
  logic            holdBusy;
  logic [HC_W-1:0] holdCnt;
  logic            dataAcc;
  logic            ctrlWr;
  logic            statWr;
  logic            relReq;

  assign dataAcc = (regRd | regWr) && (regAddr == REG_DATA);
  assign ctrlWr  = regWr && (regAddr == REG_CTRL);
  assign statWr  = regWr && (regAddr == REG_STAT);
  assign relReq  = !pinN && !holdBusy && (dataAcc || (statWr && wdPin));

  always_comb begin
    stb       = '0;
    stateNxt  = state;
    aasNxt    = aas;
    trxNxt    = trx;
    ad0Nxt    = ad0;
    alNxt     = al;
    alPendNxt = alPend;
    mstNxt    = mstSel;
    ackBitNxt = ackBit;
    raise     = 1'b0;
    if (ctrlWr) begin
      mstNxt = wdMst;
      alNxt  = 1'b0;
    end
    if (mstSel && arbLost) begin
      alPendNxt = 1'b1;
    end
    if (ev.startDet) begin
      stateNxt    = ST_ADDR;
      stb.cntClr  = 1'b1;
      stb.sdaFree = 1'b1;
      trxNxt      = 1'b0;
      ad0Nxt      = 1'b0;
    end else if (ev.stopDet) begin
      stateNxt    = ST_IDLE;
      stb.cntClr  = 1'b1;
      stb.sdaFree = 1'b1;
      aasNxt      = 1'b0;
    end else if (state != ST_IDLE) begin
      if (ev.sclRise) begin
        if (ev.bitCnt < DATA_END) begin
          stb.cntInc  = 1'b1;
          stb.shiftIn = (state != ST_TX);
        end else if (ev.bitCnt == DATA_END) begin
          stb.cntInc = 1'b1;
          ackBitNxt  = ev.sdaBit;
        end
      end else if (ev.sclFall) begin
        if (ev.bitCnt == WORD_END) begin
          stb.cntClr  = 1'b1;
          stb.sdaFree = 1'b1;
          if (alPend) begin
            raise     = 1'b1;
            alNxt     = 1'b1;
            mstNxt    = 1'b0;
            alPendNxt = 1'b0;
            stateNxt  = ST_IDLE;
          end else if (mstSel) begin
            stateNxt = ST_RX;
          end else begin
            case (state)
              ST_ADDR: begin
                raise    = 1'b1;
                stateNxt = trx ? ST_TX : ST_RX;
              end
              ST_RX: raise = 1'b1;
              ST_TX: begin
                if (!ackBit) begin
                  raise = 1'b1;
                end else begin
                  stateNxt = ST_IDLE;
                end
              end
              default: ;
            endcase
          end
        end else if (ev.bitCnt == DATA_END) begin
          if (mstSel || alPend) begin
            stb.sdaFree = 1'b1;
          end else begin
            case (state)
              ST_ADDR: begin
                if (ev.genCall || ev.addrMatch) begin
                  stb.ackLow = 1'b1;
                  aasNxt     = 1'b1;
                  trxNxt     = ev.rwBit & ~ev.genCall;
                  ad0Nxt     = ev.genCall;
                end else begin
                  stateNxt   = ST_IDLE;
                  stb.cntClr = 1'b1;
                end
              end
              ST_RX: begin
                stb.capture = 1'b1;
                stb.ackLow  = 1'b1;
              end
              ST_TX: stb.sdaFree = 1'b1;
              default: ;
            endcase
          end
        end else if (ev.bitCnt != '0 && state == ST_TX && !mstSel) begin
          stb.shiftOut = 1'b1;
        end
      end
    end
    if (regWr && regAddr == REG_DATA && state == ST_TX && !pinN) begin
      stb.loadTx = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      aas    <= 1'b0;
      trx    <= 1'b0;
      ad0    <= 1'b0;
      al     <= 1'b0;
      alPend <= 1'b0;
      mstSel <= 1'b0;
      ackBit <= 1'b1;
    end else begin
      state  <= stateNxt;
      aas    <= aasNxt;
      trx    <= trxNxt;
      ad0    <= ad0Nxt;
      al     <= alNxt;
      alPend <= alPendNxt;
      mstSel <= mstNxt;
      ackBit <= ackBitNxt;
    end
  end

  // interrupt pending, clock stretch and release hold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinN     <= 1'b1;
      sclOe    <= 1'b0;
      holdBusy <= 1'b0;
      holdCnt  <= '0;
    end else if (raise) begin
      pinN     <= 1'b0;
      sclOe    <= 1'b1;
      holdBusy <= 1'b0;
    end else if (relReq) begin
      holdBusy <= 1'b1;
      holdCnt  <= '0;
    end else if (holdBusy) begin
      if (holdCnt == HC_W'(HOLD_CYC - 1)) begin
        sclOe    <= 1'b0;
        pinN     <= 1'b1;
        holdBusy <= 1'b0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

  assign status = {pinN, al, trx, aas, ad0};

  AST_STRETCH_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    !pinN |-> sclOe); // R5
  AST_RELEASE_SETS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOe) |-> pinN); // R5
  AST_AL_LEAVES_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(al) |-> !mstSel); // R8
  AST_STOP_CLEARS_AAS: assert property (@(posedge clk) disable iff (!rstN)
    ev.stopDet |=> !aas); // R10
  AST_GC_IMPLIES_ADDRESSED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ad0) |-> aas); // R4

endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch
  import i2cs_pkg::*;
#(
  parameter int                SYNC_LEN     = 2,
  parameter int                HOLD_CYC     = 4,
  parameter logic [ADDR_W-1:0] OWN_ADDR_RST = 7'h3C
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  input  logic       arbLost,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq
);

  busEv_t            ev;
  dpStrobe_t         stb;
  logic [BYTE_W-1:0] dataBuf;
  logic [ADDR_W-1:0] ownAddr;
  logic              mstSel;
  logic [STAT_W-1:0] status;

  i2cs_datapath #(
    .SYNC_LEN    (SYNC_LEN),
    .OWN_ADDR_RST(OWN_ADDR_RST)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .stb       (stb),
    .hostDataWr(regWr && regAddr == REG_DATA),
    .hostOwnWr (regWr && regAddr == REG_OWN),
    .hostWdata (regWdata),
    .ev        (ev),
    .dataBuf   (dataBuf),
    .ownAddr   (ownAddr),
    .sdaOe     (sdaOe)
  );

  i2cs_ctrl #(
    .HOLD_CYC(HOLD_CYC)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ev     (ev),
    .arbLost(arbLost),
    .regAddr(regAddr),
    .regWr  (regWr),
    .regRd  (regRd),
    .wdMst  (regWdata[0]),
    .wdPin  (regWdata[STAT_PIN]),
    .stb    (stb),
    .sclOe  (sclOe),
    .mstSel (mstSel),
    .status (status)
  );

  always_comb begin
    case (regAddr)
      REG_DATA: regRdata = dataBuf;
      REG_CTRL: regRdata = {7'b0, mstSel};
      REG_STAT: regRdata = {{(8 - STAT_W){1'b0}}, status};
      default:  regRdata = {1'b0, ownAddr};
    endcase
  end

  assign irq = ~status[STAT_PIN];

  AST_NO_ACK_AS_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    mstSel && ev.sclFall && ev.bitCnt == CNT_W'(BYTE_W) |=> !sdaOe); // R8

endmodule

// File: tb/sim_i2c_target_stretch.sv
`timescale 1ns/1ps
module sim_i2c_target_stretch;

  localparam int HOLD = 4;
  localparam int HALF = 10;

  // {pad, addr[6:0], rw, expAck, expIrq, expStatus[4:0]}
  localparam logic [15:0] VEC [6] = '{
    {1'b0, 7'h3C, 1'b0, 1'b1, 1'b1, 5'h02},
    {1'b0, 7'h3C, 1'b1, 1'b1, 1'b1, 5'h06},
    {1'b0, 7'h00, 1'b0, 1'b1, 1'b1, 5'h03},
    {1'b0, 7'h3D, 1'b0, 1'b0, 1'b0, 5'h10},
    {1'b0, 7'h00, 1'b1, 1'b0, 1'b0, 5'h10},
    {1'b0, 7'h1C, 1'b0, 1'b0, 1'b0, 5'h10}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mScl = 1'b1;
  logic       mSda = 1'b1;
  logic       sclBus;
  logic       sdaBus;
  logic       sclOe;
  logic       sdaOe;
  logic       arbLost = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       irq;
  int         checks = 0;
  int         fails = 0;
  int         sdaViol = 0;
  logic       sdaOePrev = 1'b0;

  always #10 clk = ~clk;

  assign sclBus = mScl & ~sclOe;
  assign sdaBus = mSda & ~sdaOe;

  i2c_target_stretch u0 (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclBus),
    .sdaIn   (sdaBus),
    .sclOe   (sclOe),
    .sdaOe   (sdaOe),
    .arbLost (arbLost),
    .regAddr (regAddr),
    .regWr   (regWr),
    .regRd   (regRd),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .irq     (irq)
  );

  // R11 monitor: new SDA pull only while SCL low
  always @(negedge clk) begin
    if (rstN && sdaOe && !sdaOePrev && sclBus) sdaViol++;
    sdaOePrev = sdaOe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #5 d = regRdata;
    @(posedge clk);
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(input logic b, output logic r);
    mSda = b;
    waitCyc(HALF);
    mScl = 1'b1;
    while (sclBus !== 1'b1) @(negedge clk);
    waitCyc(HALF);
    r = sdaBus;
    mScl = 1'b0;
    waitCyc(HALF);
  endtask

  task automatic startCond();
    mSda = 1'b1;
    waitCyc(HALF);
    mScl = 1'b1;
    while (sclBus !== 1'b1) @(negedge clk);
    waitCyc(HALF);
    mSda = 1'b0;
    waitCyc(HALF);
    mScl = 1'b0;
    waitCyc(HALF);
  endtask

  task automatic stopCond();
    mSda = 1'b0;
    waitCyc(HALF);
    mScl = 1'b1;
    while (sclBus !== 1'b1) @(negedge clk);
    waitCyc(HALF);
    mSda = 1'b1;
    waitCyc(HALF);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ackd);
    logic r;
    for (int i = 7; i >= 0; i--) clockBit(b[i], r);
    clockBit(1'b1, r);
    ackd = ~r;
  endtask

  task automatic readByte(input logic nack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, r);
      v[i] = r;
    end
    clockBit(nack, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       ack;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);

    // R1 reset state
    chk("R1 sclOe", sclOe, 0);
    chk("R1 sdaOe", sdaOe, 0);
    chk("R1 irq", irq, 0);
    hostRead(2'd2, rd); chk("R1 status", rd, 8'h10);
    hostRead(2'd1, rd); chk("R1 control", rd, 8'h00);
    hostRead(2'd3, rd); chk("R1 own address", rd, 8'h3C);

    // address vectors: R2 R3 R4 R10
    for (int v = 0; v < 6; v++) begin
      startCond();
      writeByte({VEC[v][14:8], VEC[v][7]}, ack);
      chk("R2/R3/R4 address ack", ack, VEC[v][6]);
      chk("R2/R3/R4 irq", irq, VEC[v][5]);
      chk("R2 scl stretched", sclOe, VEC[v][5]);
      hostRead(2'd2, rd);
      chk("R2/R4 status", rd, {3'b0, VEC[v][4:0]});
      if (VEC[v][5]) begin
        hostWrite(2'd2, 8'h10);
        waitCyc(HOLD + 1);
      end
      stopCond();
      hostRead(2'd2, rd);
      chk("R10 aas after stop", rd[1], 0);
    end

    // R6 receive with timed release (R5)
    startCond();
    writeByte(8'h78, ack);
    chk("R2 ack own write", ack, 1);
    hostWrite(2'd2, 8'h10);
    waitCyc(HOLD + 1);
    writeByte(8'hA5, ack);
    chk("R6 data ack", ack, 1);
    chk("R6 data irq", irq, 1);
    hostRead(2'd0, rd);
    chk("R6 data value", rd, 8'hA5);
    waitCyc(HOLD - 1);
    chk("R5 scl held during hold", sclOe, 1);
    waitCyc(1);
    chk("R5 scl released after hold", sclOe, 0);
    chk("R5 irq cleared on release", irq, 0);
    writeByte(8'h5A, ack);
    chk("R6 second byte ack", ack, 1);
    hostWrite(2'd0, 8'h77);
    waitCyc(HOLD + 1);
    chk("R5 release by data write", sclOe, 0);
    stopCond();

    // R3 unmatched address, data ignored
    startCond();
    writeByte(8'h22, ack);
    chk("R3 no ack", ack, 0);
    writeByte(8'h00, ack);
    chk("R3 data not acked", ack, 0);
    chk("R3 no irq", irq, 0);
    chk("R3 no stretch", sclOe, 0);
    stopCond();
    hostRead(2'd0, rd);
    chk("R3 buffer unchanged", rd, 8'h77);

    // R4 general call with data
    startCond();
    writeByte(8'h00, ack);
    chk("R4 gc ack", ack, 1);
    hostRead(2'd2, rd);
    chk("R4 gc status", rd, 8'h03);
    hostWrite(2'd2, 8'h10);
    waitCyc(HOLD + 1);
    writeByte(8'h3E, ack);
    chk("R4 gc data ack", ack, 1);
    chk("R4 gc data irq", irq, 1);
    hostRead(2'd0, rd);
    chk("R4 gc data value", rd, 8'h3E);
    waitCyc(HOLD + 1);
    stopCond();

    // R7 transmit
    startCond();
    writeByte(8'h79, ack);
    chk("R7 read address ack", ack, 1);
    hostRead(2'd2, rd);
    chk("R7 trx set", rd, 8'h06);
    hostWrite(2'd0, 8'hC3);
    readByte(1'b0, rd);
    chk("R7 first byte", rd, 8'hC3);
    chk("R7 irq after master ack", irq, 1);
    chk("R7 stretch after master ack", sclOe, 1);
    hostWrite(2'd0, 8'h81);
    readByte(1'b1, rd);
    chk("R7 second byte", rd, 8'h81);
    chk("R7 no irq after nack", irq, 0);
    chk("R7 sda free after nack", sdaOe, 0);
    chk("R7 scl free after nack", sclOe, 0);
    stopCond();

    // R8 R9 arbitration loss handover
    hostWrite(2'd1, 8'h01);
    hostRead(2'd1, rd);
    chk("R8 master selected", rd, 8'h01);
    startCond();
    fork
      begin
        waitCyc(100);
        arbLost = 1'b1;
        waitCyc(1);
        arbLost = 1'b0;
      end
    join_none
    writeByte(8'h78, ack);
    chk("R8 no ack as master", ack, 0);
    chk("R8 irq at word end", irq, 1);
    hostRead(2'd2, rd);
    chk("R8 al status", rd, 8'h08);
    hostRead(2'd1, rd);
    chk("R8 master cleared", rd, 8'h00);
    hostWrite(2'd1, 8'h00);
    hostRead(2'd2, rd);
    chk("R9 al cleared by control write", rd[3], 0);
    hostWrite(2'd2, 8'h10);
    waitCyc(HOLD + 1);
    chk("R5 release after al", sclOe, 0);
    stopCond();

    chk("R11 sda pulled only while scl low", sdaViol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule